// File: doc/BRIEF.md
# Subset RISC Execution Core

This block is a small in-order processor core for a fixed-length, big-endian 32-bit instruction subset. Each word carries a 6-bit major opcode in its top bits, two 5-bit register selectors and a 16-bit immediate. The core has 32 general registers, and register 0 always reads as zero. It covers the operations a compiled calling convention relies on. Load-high and an address add build constants and pointers. A word load and a word store, both relative to a base register, serve stack save and restore. A signed compare sets a single flag. Jumps, a flag-conditional jump, a call and a register return each execute one delay-slot instruction before control moves.

The core is built around a three-state machine. FETCH presents the program counter on the instruction port. EXECUTE decodes the word returned by the synchronous instruction memory, does the work and issues any store. WRITEBACK is entered only after a load, to commit the synchronous data-memory read into a register. The transitions are: FETCH to EXECUTE always; EXECUTE to WRITEBACK for a load; EXECUTE to FETCH for every other instruction; WRITEBACK to FETCH always. Both memories are word memories with byte addresses and a one-cycle read latency. Call arguments travel in registers 3 and up. A callee saves and restores registers through the store and load instructions.

Top module: `core_subset_cpu`

## Requirements
- R1: While reset is held and right after it, the fetch address equals the reset address, no write is issued and the illegal-instruction status is low.
- R2: Bits 31:26 are the opcode, bits 25:21 the destination, bits 20:16 the source or base, and bits 15:0 the immediate. Opcode 0x06 writes the immediate into bits 31:16 of the destination and zero into bits 15:0.
- R3: Opcode 0x2A writes the source register plus the zero-extended 16-bit immediate into the destination.
- R4: Register 0 reads as zero, and every write aimed at it is discarded.
- R5: Opcode 0x35 writes the register selected by bits 15:11 to the address base (bits 20:16) plus a sign-extended offset. The offset's upper five bits are bits 25:21 and its lower eleven bits are bits 10:0. The write happens in the execute cycle, and each store gives exactly one write cycle.
- R6: Opcode 0x21 loads the word at base (bits 20:16) plus the sign-extended immediate into the destination.
- R7: Opcode 0x2F sets the flag when the register at bits 25:21 is greater than the register at bits 20:16 as signed numbers, and clears it otherwise. The flag keeps its value until the next compare.
- R8: Opcode 0x00 jumps to its own address plus four times the sign-extended field in bits 25:0. The instruction after the jump (the delay slot) always executes first.
- R9: Opcode 0x04 takes the same target as R8 only when the flag is set. Its delay slot executes in both cases.
- R10: Opcode 0x01 jumps like R8 and writes its own address plus 8 into register 9.
- R11: Opcode 0x11 jumps, after its delay slot, to the address held in the register selected by bits 15:11.
- R12: Any other opcode changes no register, memory or flag, and it sets an illegal-instruction status that stays high until reset.
- R13: Every instruction takes two cycles (fetch, execute), and a load takes three (fetch, execute, writeback). The fetch address changes only at the end of an execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_data | input | 32 | Instruction word, valid one cycle after the address |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid one cycle after the address |
| illegal_seen | output | 1 | Sticky flag for an unrecognised opcode |

## Verification
Five short programs run from reset. A cycle-level reference model steps each program and predicts the fetch address, store strobe, store address, store data and illegal status on every clock. Constant-building programs combine load-high and the address add with all-ones immediates, a negative split store offset and writes to register 0. These separate zero-extension from sign-extension and show whether field bits are misplaced. A load program reads below and above its base and re-reads a freshly stored word, which tests the offset sign and the writeback timing. Branch programs compare a positive value against a negative one and equal values, then take and skip conditional jumps. Calls and returns run with live delay slots and a backward jump. These expose a swapped compare order, an unsigned compare, a delay slot that is dropped or duplicated, and a wrong link value. A program with two undefined opcodes shows that nothing is written and that the status stays sticky.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN   = 32;
    localparam int OP_W   = 6;
    localparam int RA_W   = 5;
    localparam int NREG   = 1 << RA_W;
    localparam int IMM_W  = 16;
    localparam int JOFF_W = XLEN - OP_W;

    localparam logic [OP_W-1:0] OP_JMP  = 6'h00;
    localparam logic [OP_W-1:0] OP_CALL = 6'h01;
    localparam logic [OP_W-1:0] OP_JGT  = 6'h04;
    localparam logic [OP_W-1:0] OP_LDHI = 6'h06;
    localparam logic [OP_W-1:0] OP_RET  = 6'h11;
    localparam logic [OP_W-1:0] OP_LDW  = 6'h21;
    localparam logic [OP_W-1:0] OP_ADDI = 6'h2A;
    localparam logic [OP_W-1:0] OP_CMP  = 6'h2F;
    localparam logic [OP_W-1:0] OP_STW  = 6'h35;

    typedef enum logic [1:0] {
        S_FETCH = 2'd0,
        S_EXEC  = 2'd1,
        S_WB    = 2'd2
    } state_e;

    typedef enum logic [3:0] {
        K_LDHI, K_ADDI, K_CMP, K_STW, K_LDW,
        K_JMP, K_JGT, K_CALL, K_RET, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RA_W-1:0]   rd;
        logic [RA_W-1:0]   ra;
        logic [RA_W-1:0]   rb;
        logic [XLEN-1:0]   imm_hi;
        logic [XLEN-1:0]   imm_z;
        logic [XLEN-1:0]   imm_s;
        logic [XLEN-1:0]   imm_st;
        logic [XLEN-1:0]   joff;
    } dec_t;

endpackage

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int N  = NREG,
    parameter int W  = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (we && wa == AW'(g)) begin
                    regs[g] <= wd;
                end
            end
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

endmodule

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    logic [OP_W-1:0]   op;
    logic [IMM_W-1:0]  imm;
    logic [IMM_W-1:0]  st_off;
    logic [JOFF_W-1:0] jfield;

    assign op     = instr[XLEN-1 -: OP_W];
    assign imm    = instr[IMM_W-1:0];
    assign st_off = {instr[25:21], instr[10:0]};
    assign jfield = instr[JOFF_W-1:0];

    always_comb begin
        dec.rd     = instr[25:21];
        dec.ra     = instr[20:16];
        dec.rb     = instr[15:11];
        dec.imm_hi = {imm, {(XLEN-IMM_W){1'b0}}};
        dec.imm_z  = {{(XLEN-IMM_W){1'b0}}, imm};
        dec.imm_s  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        dec.imm_st = {{(XLEN-IMM_W){st_off[IMM_W-1]}}, st_off};
        dec.joff   = {{(XLEN-JOFF_W-2){jfield[JOFF_W-1]}}, jfield, 2'b00};
        unique case (op)
            OP_LDHI: dec.kind = K_LDHI;
            OP_ADDI: dec.kind = K_ADDI;
            OP_CMP:  dec.kind = K_CMP;
            OP_STW:  dec.kind = K_STW;
            OP_LDW:  dec.kind = K_LDW;
            OP_JMP:  dec.kind = K_JMP;
            OP_JGT:  dec.kind = K_JGT;
            OP_CALL: dec.kind = K_CALL;
            OP_RET:  dec.kind = K_RET;
            default: dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/core_exec.sv
module core_exec
    import core_pkg::*;
#(
    parameter int LINK_REG = 9
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] npc,
    input  logic [XLEN-1:0] val_d,
    input  logic [XLEN-1:0] val_a,
    input  logic [XLEN-1:0] val_b,
    input  logic            flag_in,
    output logic            wr_en,
    output logic [RA_W-1:0] wr_sel,
    output logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] mem_addr,
    output logic            is_store,
    output logic            is_load,
    output logic            flag_we,
    output logic            flag_val,
    output logic [XLEN-1:0] npc_next,
    output logic            bad
);

    localparam int PC_STEP = XLEN / 8;

    logic [XLEN-1:0] seq_npc;
    logic [XLEN-1:0] rel_target;

    assign seq_npc    = npc + XLEN'(PC_STEP);
    assign rel_target = pc + dec.joff;

    always_comb begin
        wr_en    = 1'b0;
        wr_sel   = dec.rd;
        wr_val   = '0;
        mem_addr = val_a + dec.imm_s;
        is_store = 1'b0;
        is_load  = 1'b0;
        flag_we  = 1'b0;
        flag_val = $signed(val_d) > $signed(val_a);
        npc_next = seq_npc;
        bad      = 1'b0;
        unique case (dec.kind)
            K_LDHI: begin
                wr_en  = 1'b1;
                wr_val = dec.imm_hi;
            end
            K_ADDI: begin
                wr_en  = 1'b1;
                wr_val = val_a + dec.imm_z;
            end
            K_CMP: begin
                flag_we = 1'b1;
            end
            K_STW: begin
                is_store = 1'b1;
                mem_addr = val_a + dec.imm_st;
            end
            K_LDW: begin
                is_load = 1'b1;
            end
            K_JMP: begin
                npc_next = rel_target;
            end
            K_JGT: begin
                if (flag_in) npc_next = rel_target;
            end
            K_CALL: begin
                wr_en    = 1'b1;
                wr_sel   = RA_W'(LINK_REG);
                wr_val   = pc + XLEN'(2 * PC_STEP);
                npc_next = rel_target;
            end
            K_RET: begin
                npc_next = val_b;
            end
            K_BAD: begin
                bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/core_subset_cpu.sv
module core_subset_cpu
    import core_pkg::*;
#(
    parameter logic [31:0] RESET_ADDR = 32'h0000_0000,
    parameter int          LINK_REG   = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic        dmem_we,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata,
    output logic        illegal_seen
);

    localparam logic [XLEN-1:0] RESET_NPC = RESET_ADDR + XLEN'(XLEN / 8);

    state_e            state_q, state_d;
    logic [XLEN-1:0]   pc_q, npc_q;
    logic              flag_q, bad_q;
    logic [RA_W-1:0]   ld_dst_q;

    dec_t              dec;
    logic [XLEN-1:0]   val_d, val_a, val_b;
    logic              ex_wr, ex_store, ex_load, ex_flag_we, ex_flag, ex_bad;
    logic [RA_W-1:0]   ex_wsel;
    logic [XLEN-1:0]   ex_wval, ex_addr, ex_npc;

    logic              rf_we;
    logic [RA_W-1:0]   rf_wa;
    logic [XLEN-1:0]   rf_wd;

    core_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    core_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (dec.rd),
        .ra2   (dec.ra),
        .ra3   (dec.rb),
        .rd1   (val_d),
        .rd2   (val_a),
        .rd3   (val_b),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    core_exec #(.LINK_REG(LINK_REG)) u_exec (
        .dec      (dec),
        .pc       (pc_q),
        .npc      (npc_q),
        .val_d    (val_d),
        .val_a    (val_a),
        .val_b    (val_b),
        .flag_in  (flag_q),
        .wr_en    (ex_wr),
        .wr_sel   (ex_wsel),
        .wr_val   (ex_wval),
        .mem_addr (ex_addr),
        .is_store (ex_store),
        .is_load  (ex_load),
        .flag_we  (ex_flag_we),
        .flag_val (ex_flag),
        .npc_next (ex_npc),
        .bad      (ex_bad)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH: state_d = S_EXEC;
            S_EXEC:  state_d = ex_load ? S_WB : S_FETCH;
            S_WB:    state_d = S_FETCH;
        endcase
    end

    // Outputs and register-file write selection per state
    always_comb begin
        dmem_we = 1'b0;
        rf_we   = 1'b0;
        rf_wa   = ld_dst_q;
        rf_wd   = dmem_rdata;
        unique case (state_q)
            S_FETCH: ;
            S_EXEC: begin
                dmem_we = ex_store;
                rf_we   = ex_wr;
                rf_wa   = ex_wsel;
                rf_wd   = ex_wval;
            end
            S_WB: begin
                rf_we = 1'b1;
            end
        endcase
    end

    // Architectural state updated at the end of the execute cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_ADDR;
            npc_q    <= RESET_NPC;
            flag_q   <= 1'b0;
            bad_q    <= 1'b0;
            ld_dst_q <= '0;
        end else if (state_q == S_EXEC) begin
            pc_q     <= npc_q;
            npc_q    <= ex_npc;
            ld_dst_q <= dec.rd;
            if (ex_flag_we) flag_q <= ex_flag;
            if (ex_bad)     bad_q  <= 1'b1;
        end
    end

    assign imem_addr    = pc_q;
    assign dmem_addr    = ex_addr;
    assign dmem_wdata   = val_b;
    assign illegal_seen = bad_q;

endmodule

// File: rtl/core_subset_cpu_chk.sv
module core_subset_cpu_chk
    import core_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we,
    input logic        illegal_seen,
    input logic        cmp_flag,
    input state_e      state
);

    // R12
    sticky_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_seen |=> illegal_seen);

    // R5
    single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

    // R5
    store_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> state == S_EXEC);

    // R13
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(imem_addr) |=> $stable(imem_addr));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_flag) |-> $past(state == S_EXEC && imem_data[31:26] == OP_CMP));

endmodule

bind core_subset_cpu core_subset_cpu_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .imem_addr    (imem_addr),
    .imem_data    (imem_data),
    .dmem_we      (dmem_we),
    .illegal_seen (illegal_seen),
    .cmp_flag     (flag_q),
    .state        (state_q)
);

// File: tb/test_core_subset_cpu.sv
`timescale 1ns/1ps
module test_core_subset_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, illegal_seen;

    always #2.5 clk = ~clk;

    core_subset_cpu i_core_subset_cpu (
        .clk          (clk),
        .rst_n        (rst_n),
        .imem_addr    (imem_addr),
        .imem_data    (imem_data),
        .dmem_addr    (dmem_addr),
        .dmem_we      (dmem_we),
        .dmem_wdata   (dmem_wdata),
        .dmem_rdata   (dmem_rdata),
        .illegal_seen (illegal_seen)
    );

    logic [31:0] imem [256];
    logic [31:0] dmem [256];
    logic [31:0] mmem [256];

    always @(posedge clk) begin
        imem_data  <= imem[imem_addr[9:2]];
        dmem_rdata <= dmem[dmem_addr[9:2]];
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
    end

    int checks = 0;
    int errors = 0;

    logic [31:0] q_ia[$], q_da[$], q_dw[$];
    bit          q_we[$], q_il[$];

    localparam logic [31:0] NOP = {6'h2A, 26'h0};

    function automatic logic [31:0] e_i(logic [5:0] op, int d, int a, logic [15:0] imm);
        return {op, 5'(d), 5'(a), imm};
    endfunction
    function automatic logic [31:0] e_st(int base, int src, logic [15:0] off);
        return {6'h35, off[15:11], 5'(base), 5'(src), off[10:0]};
    endfunction
    function automatic logic [31:0] e_j(logic [5:0] op, int words);
        return {op, 26'(words)};
    endfunction
    function automatic logic [31:0] e_cmp(int x, int y);
        return {6'h2F, 5'(x), 5'(y), 16'h0};
    endfunction
    function automatic logic [31:0] e_ret(int r);
        return {6'h11, 10'h0, 5'(r), 11'h0};
    endfunction

    task automatic push(logic [31:0] ia, bit we, logic [31:0] da, logic [31:0] dw, bit il);
        q_ia.push_back(ia); q_we.push_back(we); q_da.push_back(da);
        q_dw.push_back(dw); q_il.push_back(il);
    endtask

    // Behavioural reference: one instruction at a time, emitting expected per-cycle outputs
    task automatic model_run(int ncyc);
        logic [31:0] r [32];
        logic [31:0] pc, npc, ins, nxt, va, vd, vb, addr, wv;
        logic [15:0] so;
        bit fl, ill, st, ld, wr, bad;
        int wd;
        for (int i = 0; i < 32; i++) r[i] = 0;
        pc = 0; npc = 4; fl = 0; ill = 0;
        while (q_ia.size() < ncyc) begin
            ins = imem[pc[9:2]];
            push(pc, 0, 0, 0, ill);
            vd = r[ins[25:21]]; va = r[ins[20:16]]; vb = r[ins[15:11]];
            nxt = npc + 4; st = 0; ld = 0; wr = 0; bad = 0;
            wd = ins[25:21]; wv = 0;
            addr = va + {{16{ins[15]}}, ins[15:0]};
            case (ins[31:26])
                6'h06: begin wr = 1; wv = {ins[15:0], 16'h0}; end
                6'h2A: begin wr = 1; wv = va + {16'h0, ins[15:0]}; end
                6'h2F: fl = $signed(vd) > $signed(va);
                6'h35: begin
                    st = 1; so = {ins[25:21], ins[10:0]};
                    addr = va + {{16{so[15]}}, so};
                end
                6'h21: ld = 1;
                6'h00: nxt = pc + {{4{ins[25]}}, ins[25:0], 2'b00};
                6'h04: if (fl) nxt = pc + {{4{ins[25]}}, ins[25:0], 2'b00};
                6'h01: begin
                    nxt = pc + {{4{ins[25]}}, ins[25:0], 2'b00};
                    wr = 1; wd = 9; wv = pc + 8;
                end
                6'h11: nxt = vb;
                default: bad = 1;
            endcase
            push(pc, st, addr, vb, ill);
            if (st) mmem[addr[9:2]] = vb;
            if (bad) ill = 1;
            if (wr && wd != 0) r[wd] = wv;
            pc = npc; npc = nxt;
            if (ld) begin
                push(pc, 0, 0, 0, ill);
                if (ins[25:21] != 0) r[ins[25:21]] = mmem[addr[9:2]];
            end
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin imem[i] = NOP; dmem[i] = 0; mmem[i] = 0; end
    endtask

    task automatic run_prog(string tag, int ncyc);
        q_ia.delete(); q_we.delete(); q_da.delete(); q_dw.delete(); q_il.delete();
        model_run(ncyc);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset fetch address", imem_addr, 32'h0);
        chk("R1", "reset write enable", {31'h0, dmem_we}, 32'h0);
        chk("R1", "reset illegal status", {31'h0, illegal_seen}, 32'h0);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < ncyc; k++) begin
            if (k > 0) begin @(negedge clk); #1; end
            chk({tag, " R13"}, $sformatf("cycle %0d fetch address", k), imem_addr, q_ia[k]);
            chk(tag, $sformatf("cycle %0d write enable", k), {31'h0, dmem_we}, {31'h0, q_we[k]});
            if (q_we[k]) begin
                chk(tag, $sformatf("cycle %0d store address", k), dmem_addr, q_da[k]);
                chk(tag, $sformatf("cycle %0d store data", k), dmem_wdata, q_dw[k]);
            end
            chk("R12", $sformatf("cycle %0d illegal status", k), {31'h0, illegal_seen}, {31'h0, q_il[k]});
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R2 R3 R4 R5: constants, zero register, split store offset
        clear_mem();
        imem[0]  = e_i(6'h06, 3, 0, 16'h1234);
        imem[1]  = e_i(6'h2A, 3, 3, 16'h8765);
        imem[2]  = e_i(6'h2A, 1, 0, 16'h0100);
        imem[3]  = e_st(1, 3, 16'h0004);
        imem[4]  = e_i(6'h2A, 0, 0, 16'h0005);
        imem[5]  = e_st(1, 0, 16'h0008);
        imem[6]  = e_i(6'h06, 4, 0, 16'hFFFF);
        imem[7]  = e_i(6'h2A, 4, 4, 16'hFFFF);
        imem[8]  = e_st(1, 4, 16'hFFFC);
        imem[9]  = e_i(6'h06, 0, 0, 16'hABCD);
        imem[10] = e_st(1, 0, 16'h07F0);
        imem[11] = e_j(6'h00, 0);
        run_prog("R2 R3 R4 R5", 50);

        // R6: loads with positive and negative offsets, load after store
        clear_mem();
        dmem[8'h80] = 32'hCAFE_F00D; mmem[8'h80] = 32'hCAFE_F00D;
        dmem[8'h7F] = 32'h1122_3344; mmem[8'h7F] = 32'h1122_3344;
        imem[0] = e_i(6'h2A, 1, 0, 16'h0200);
        imem[1] = e_i(6'h21, 2, 1, 16'h0000);
        imem[2] = e_i(6'h21, 6, 1, 16'hFFFC);
        imem[3] = e_st(1, 2, 16'h0008);
        imem[4] = e_st(1, 6, 16'h000C);
        imem[5] = e_i(6'h21, 7, 1, 16'h0008);
        imem[6] = e_st(1, 7, 16'h0010);
        imem[7] = e_i(6'h21, 0, 1, 16'h0000);
        imem[8] = e_st(1, 0, 16'h0014);
        imem[9] = e_j(6'h00, 0);
        run_prog("R6", 60);

        // R7 R9: signed compare, held flag, taken and untaken conditional jumps
        clear_mem();
        imem[0]  = e_i(6'h2A, 5, 0, 16'h0005);
        imem[1]  = e_i(6'h06, 6, 0, 16'hFFFF);
        imem[2]  = e_i(6'h2A, 1, 0, 16'h0100);
        imem[3]  = e_cmp(5, 6);
        imem[4]  = e_j(6'h04, 3);
        imem[5]  = e_st(1, 5, 16'h0000);
        imem[6]  = e_st(1, 6, 16'h0004);
        imem[7]  = e_cmp(6, 5);
        imem[8]  = NOP;
        imem[9]  = e_j(6'h04, 3);
        imem[10] = e_st(1, 1, 16'h0008);
        imem[11] = e_st(1, 5, 16'h000C);
        imem[12] = e_cmp(5, 5);
        imem[13] = e_j(6'h04, 3);
        imem[14] = e_st(1, 5, 16'h0010);
        imem[15] = e_cmp(5, 6);
        imem[16] = e_st(1, 6, 16'h0014);
        imem[17] = e_j(6'h04, 2);
        imem[18] = NOP;
        imem[19] = e_st(1, 6, 16'h0018);
        imem[20] = e_j(6'h00, 0);
        run_prog("R7 R9", 70);

        // R8 R10 R11: call with delay slot, return, forward and backward jumps
        clear_mem();
        imem[0]  = e_i(6'h2A, 1, 0, 16'h0100);
        imem[1]  = e_i(6'h2A, 3, 0, 16'h0007);
        imem[2]  = e_j(6'h01, 6);
        imem[3]  = e_i(6'h2A, 3, 3, 16'h0001);
        imem[4]  = e_st(1, 3, 16'h0000);
        imem[5]  = e_st(1, 9, 16'h0004);
        imem[6]  = e_j(6'h00, 6);
        imem[7]  = e_st(1, 1, 16'h0020);
        imem[8]  = e_st(1, 3, 16'h0008);
        imem[9]  = e_ret(9);
        imem[10] = e_i(6'h2A, 3, 3, 16'h0010);
        imem[11] = e_st(1, 3, 16'h000C);
        imem[12] = e_st(1, 1, 16'h0010);
        imem[13] = e_j(6'h00, -1);
        imem[14] = e_i(6'h2A, 1, 1, 16'h0004);
        run_prog("R8 R10 R11", 70);

        // R12: undefined opcodes write nothing and set the sticky status
        clear_mem();
        imem[0] = e_i(6'h2A, 1, 0, 16'h0100);
        imem[1] = {6'h3F, 5'd2, 5'd0, 16'h0055};
        imem[2] = e_st(1, 2, 16'h0000);
        imem[3] = {6'h03, 5'd1, 5'd1, 16'h0010};
        imem[4] = e_st(1, 1, 16'h0004);
        imem[5] = e_j(6'h00, 0);
        run_prog("R12", 40);

        summary();
        $finish;
    end

endmodule